// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI master from the bus clock. A mode input selects one of two division laws. In power-of-two mode a 4-bit divider field gives a half period of 2^field bus cycles, so the full period is 2^(field+1) cycles. In linear mode an 8-bit field gives a half period of field+1 cycles, so the full period is 2*(field+1) cycles. Besides the serial clock level, the block emits two one-cycle strobes. One marks the cycle in which the clock rises and the other the cycle in which it falls, so a shift engine can sample and launch data without detecting the edges itself.

The generator is built around a three-state machine.
- `SC_IDLE`: the clock is held low and the half-period counter is reloaded on every cycle.
- `SC_LOW`: the low half of a period.
- `SC_HIGH`: the high half of a period.

The transitions are:
- **start** (`SC_IDLE`→`SC_LOW`): taken when enable is high. It latches the mode and divider.
- **rise** (`SC_LOW`→`SC_HIGH`): taken when the counter expires. It raises the clock and pulses the leading strobe.
- **fall** (`SC_HIGH`→`SC_LOW`): taken when the counter expires. It lowers the clock and pulses the trailing strobe.
- **abort** (`SC_LOW` or `SC_HIGH`→`SC_IDLE`): taken as soon as enable drops.

Because the settings are captured only on **start**, a running transfer never sees its period change. New settings apply after the next restart.

Top module: `sclk_divgen`

## Requirements
- R1: While reset is asserted, and in every cycle after a clock edge that saw `en` low, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: With `lin_mode`=0 each half period lasts 2^`div_val[3:0]` bus cycles. `div_val[7:4]` has no effect.
- R3: With `lin_mode`=1 each half period lasts `div_val`+1 bus cycles, giving a period of 2*(`div_val`+1).
- R4: Call the first clock edge that sees `en` high with the block idle edge 0, and let H be the half period. Then `sclk` rises after edge H, falls after edge 2H, and keeps alternating every H edges.
- R5: `lead_stb` is high for exactly one cycle, the first cycle in which `sclk` is 1 after being 0. `trail_stb` is high for exactly one cycle, the first cycle in which `sclk` is 0 after a completed high half. The two strobes are never high together.
- R6: A field value of 0 in either mode gives a strobe in every bus cycle, so the edge rate equals the bus clock rate.
- R7: Changes on `lin_mode` and `div_val` while the generator runs do not alter its period until it is restarted from idle.
- R8: Dropping `en` mid-period returns `sclk` to 0 in the next cycle without a trailing strobe. A later restart follows the R4 timing afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request; low forces idle |
| lin_mode | input | 1 | 0 = power-of-two law, 1 = linear law |
| div_val | input | 8 | Divider field (low 4 bits used in power-of-two mode) |
| sclk | output | 1 | Serial clock level, idle low |
| lead_stb | output | 1 | One-cycle strobe in the cycle `sclk` rises |
| trail_stb | output | 1 | One-cycle strobe in the cycle `sclk` falls after a full high half |

## Verification
The assertions assume that reset is applied before `en` is first raised, and that `en`, `lin_mode` and `div_val` change only between clock edges. The bench drives all inputs on the falling edge, so it stays within both assumptions. The high-half length assertion also assumes the divider captured at **start** stays the reference for a whole run. The bench therefore deliberately scrambles `lin_mode` and `div_val` one cycle after each start, and the assertion checks against the captured copy rather than the live inputs.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_LOW  = 2'd1,
        SC_HIGH = 2'd2
    } sc_state_t;
endpackage

// File: rtl/spiclk_halfcalc.sv
// Converts mode + divider field into (half period - 1) in bus cycles.
module spiclk_halfcalc #(
    parameter int PWR_W  = 4,
    parameter int LIN_W  = 8,
    parameter int HALF_W = 15
) (
    input  logic              lin_mode,
    input  logic [LIN_W-1:0]  div,
    output logic [HALF_W-1:0] hm1
);
    logic [HALF_W:0]   pow_full;
    logic [HALF_W:0]   pow_m1;
    logic [HALF_W-1:0] lin_ext;

    generate
        if (HALF_W > LIN_W) begin : g_ext
            assign lin_ext = {{(HALF_W-LIN_W){1'b0}}, div};
        end else begin : g_same
            assign lin_ext = div[HALF_W-1:0];
        end
    endgenerate

    always_comb begin
        pow_full = {{HALF_W{1'b0}}, 1'b1} << div[PWR_W-1:0];
        pow_m1   = pow_full - 1'b1;
        hm1      = lin_mode ? lin_ext : pow_m1[HALF_W-1:0];
    end
endmodule

// File: rtl/spiclk_cfghold.sv
// Captures the computed half period when the generator starts.
module spiclk_cfghold #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (capture) q <= d;
    end
endmodule

// File: rtl/spiclk_halfcnt.sv
// Down counter for one half period; flags expiry at zero.
module spiclk_halfcnt #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen #(
    parameter int PWR_W = 4,
    parameter int LIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             lin_mode,
    input  logic [LIN_W-1:0] div_val,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    import spiclk_pkg::*;

    localparam int POW_HM1_W = (1 << PWR_W) - 1;
    localparam int HALF_W    = (POW_HM1_W > LIN_W) ? POW_HM1_W : LIN_W;

    sc_state_t         state_q, state_d;
    logic [HALF_W-1:0] hm1_now, hm1_held, cnt_val;
    logic              running, capture, cnt_load, expired;

    spiclk_halfcalc #(.PWR_W(PWR_W), .LIN_W(LIN_W), .HALF_W(HALF_W)) u_calc (
        .lin_mode (lin_mode),
        .div      (div_val),
        .hm1      (hm1_now)
    );

    spiclk_cfghold #(.W(HALF_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .d       (hm1_now),
        .q       (hm1_held)
    );

    spiclk_halfcnt #(.W(HALF_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (expired)
    );

    assign running  = (state_q != SC_IDLE);
    assign capture  = !running && en;
    assign cnt_load = !running || (state_d != state_q);
    assign cnt_val  = running ? hm1_held : hm1_now;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE: if (en) state_d = SC_LOW;
            SC_LOW: begin
                if (!en)          state_d = SC_IDLE;
                else if (expired) state_d = SC_HIGH;
            end
            SC_HIGH: begin
                if (!en)          state_d = SC_IDLE;
                else if (expired) state_d = SC_LOW;
            end
            default:              state_d = SC_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SC_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk      <= 1'b0;
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else begin
            sclk      <= (state_d == SC_HIGH);
            lead_stb  <= (state_q != SC_HIGH) && (state_d == SC_HIGH);
            trail_stb <= (state_q == SC_HIGH) && (state_d == SC_LOW);
        end
    end
endmodule

// File: rtl/spiclk_div_chk.sv
module spiclk_div_chk #(
    parameter int HALF_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              sclk,
    input logic              lead_stb,
    input logic              trail_stb,
    input logic              running,
    input logic [HALF_W-1:0] hm1_held
);
    logic [HALF_W:0] high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        high_cnt <= '0;
        else if (lead_stb) high_cnt <= {{HALF_W{1'b0}}, 1'b1};
        else if (sclk)     high_cnt <= high_cnt + 1'b1;
    end

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sclk && !lead_stb && !trail_stb));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    assert_lead_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> lead_stb);

    assert_lead_only_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> $rose(sclk));

    assert_trail_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> $fell(sclk));

    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> $stable(hm1_held));

    // Covers R2 and R3: high half lasts the captured half period
    assert_high_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (high_cnt == ({1'b0, hm1_held} + 1'b1)));
endmodule

bind sclk_divgen spiclk_div_chk #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .running   (running),
    .hm1_held  (hm1_held)
);

// File: tb/sim_sclk_divgen.sv
module sim_sclk_divgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       lin_mode = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic       sclk, lead_stb, trail_stb;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sclk_divgen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .lin_mode(lin_mode),
        .div_val(div_val), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_check(input string tag);
        check(!sclk && !lead_stb && !trail_stb, tag,
              {29'd0, sclk, lead_stb, trail_stb}, 0);
    endtask

    // Start a run and compare every cycle with the arithmetic model.
    // abort_at >= 0 drops en after sample abort_at.
    task automatic run_cfg(input bit m, input logic [7:0] d, input int abort_at);
        int h, last, first_lead;
        bit sc_ok, st_ok;
        int sc_act, sc_exp, st_act, st_exp;
        string law;
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        idle_check("R1 idle before start");
        h = m ? (int'(d) + 1) : (1 << d[3:0]);
        law = (h == 1) ? "R6 fastest" : (m ? "R3 R7 linear" : "R2 R7 power");
        lin_mode = m;
        div_val = d;
        en = 1'b1;
        last = (abort_at >= 0) ? abort_at : 2 * h;
        sc_ok = 1'b1; st_ok = 1'b1; first_lead = -1;
        sc_act = 0; sc_exp = 0; st_act = 0; st_exp = 0;
        for (int j = 0; j <= last; j++) begin
            int k;
            bit e_sc, e_ld, e_tr;
            @(negedge clk);
            k = j / h;
            e_sc = (k % 2) == 1;
            e_ld = ((j % h) == 0) && e_sc;
            e_tr = ((j % h) == 0) && !e_sc && (k > 0);
            if (lead_stb && first_lead < 0) first_lead = j;
            if (sclk !== e_sc && sc_ok) begin
                sc_ok = 1'b0; sc_act = j * 2 + int'(sclk); sc_exp = j * 2 + int'(e_sc);
            end
            if ((lead_stb !== e_ld || trail_stb !== e_tr) && st_ok) begin
                st_ok = 1'b0;
                st_act = j * 4 + int'({lead_stb, trail_stb});
                st_exp = j * 4 + int'({e_ld, e_tr});
            end
            if (j == 0) begin
                // R7: scramble settings while running
                lin_mode = ~m;
                div_val = ~d;
            end
        end
        check(sc_ok, law, sc_act, sc_exp);
        check(st_ok, "R5 strobes", st_act, st_exp);
        if (abort_at < 0 || abort_at >= h)
            check(first_lead == h, "R4 first rise", first_lead, h);
        if (abort_at >= 0) begin
            en = 1'b0;
            @(negedge clk);
            idle_check("R8 abort");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 after reset, en low");

        // Power-of-two law, with upper nibble noise (R2)
        for (int f = 0; f <= 12; f++)
            run_cfg(1'b0, 8'(f) | ((f % 2) != 0 ? 8'hA0 : 8'h00), -1);
        run_cfg(1'b0, 8'h5F, -1);               // largest half period

        // Linear law sweep (R3, R6 at 0)
        for (int f = 0; f <= 127; f++)
            run_cfg(1'b1, 8'(f), -1);
        run_cfg(1'b1, 8'd200, -1);
        run_cfg(1'b1, 8'd255, -1);

        // R8: abort in high half, then in low half, each followed by a clean run
        run_cfg(1'b1, 8'd3, 5);
        run_cfg(1'b1, 8'd1, -1);
        run_cfg(1'b0, 8'd2, 2);
        run_cfg(1'b0, 8'd1, -1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule